// File: doc/BRIEF.md
# Serial Flash Command Engine

This block lets software run one serial flash command at a time through three registers. The three registers are a control word, a 24-bit address and an 8-bit data byte. It drives a single flash device through a four-wire SPI master port: clock, active-low select, data out and data in. Software fills the address and data registers, then writes the control word with its start bit set. The engine asserts select, clocks out the opcode, optionally the three address bytes (most significant first), and optionally one full-duplex data byte. In that data byte the data register is shifted out while the incoming byte is captured back into the same register. The start bit stays set as a busy indication until the last bit has been clocked.

A hold flag in the control word leaves select asserted when the command ends. While select is held this way, every further command clocks only its data byte, with no opcode and no address. A page program can therefore be streamed one byte per command. Writing the value zero to the control register ends a held transaction by releasing select. When the captured byte is a flash status byte, bit 0 reports a write in progress, bit 1 the write-enable latch, bits 4:2 the block protection and bit 7 the status-register write lock. The engine itself does not interpret these bits.

Top module: `spi_flash_cmd_engine`

## Requirements
- R1: After reset spi_cs_n is 1, spi_sclk is 0, and the control (offset 0x40), address (0x44) and data (0x48) registers all read zero.
- R2: Control reads {start[31], zeros[30:13], hold[12], phase[11:8], opcode[7:0]}. The address register keeps and returns bits 23:0, and the data register keeps and returns bits 7:0. All other bits, and any other offset, read zero.
- R3: A control write with bit 31 set while idle starts a command and drives spi_cs_n low. Bit 31 reads 1 until the command completes and then clears by itself, while opcode, phase and hold keep their written values.
- R4: The phase code selects the frame. Code 0 sends the opcode (8 clocks). Code 1 sends the opcode and a data byte (16 clocks). Code 2 sends the opcode and the 24-bit address (32 clocks). Code 3 sends the opcode, the address and a data byte (40 clocks). Codes 4 to 15 behave as code 0.
- R5: SPI mode 0, MSB first. spi_sclk is low whenever select is deasserted, spi_mosi changes only while spi_sclk is low, and the rising edges of one command are CLK_DIV system clocks apart.
- R6: In a data byte the data register is shifted out and the byte sampled on spi_miso replaces it. Commands without a data byte leave the data register unchanged.
- R7: A command with the hold bit set leaves spi_cs_n low after completion. While select is held, any started command sends only its data byte (8 clocks) whatever its phase code. Its own hold bit then decides whether select stays low.
- R8: Writing zero to the control register while idle drives spi_cs_n high and ends the held state, so the next command sends its full frame again.
- R9: Register writes to any offset while a command runs are ignored, including a control write of zero.
- R10: A nonzero control write with bit 31 clear, while idle, stores the fields without starting a command or changing spi_cs_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| spi_sclk | output | 1 | SPI serial clock, idle low |
| spi_cs_n | output | 1 | Flash select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The bench builds the engine with CLK_DIV = 4, so each serial clock half period spans two system clocks. This exercises the divider's counter path and makes the spacing of rising edges measurable at the pins. It sweeps all sixteen phase codes twice, each time with fresh opcode, address, data and incoming bit patterns, so every frame length and the capture position of the returned byte are computed and compared. Held chains, release by writing zero, writes during a busy command and a store-only control write are then run as directed sequences against a bench model of the flash pins.

// File: rtl/spi_fce_pkg.sv
package spi_fce_pkg;

    localparam int unsigned OFF_CTRL = 'h40;
    localparam int unsigned OFF_ADDR = 'h44;
    localparam int unsigned OFF_DATA = 'h48;

    localparam int OP_W    = 8;
    localparam int ADR_W   = 24;
    localparam int DAT_W   = 8;
    localparam int FRAME_W = OP_W + ADR_W + DAT_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef enum logic [3:0] {
        PH_OP       = 4'd0,
        PH_OP_DAT   = 4'd1,
        PH_OP_ADR   = 4'd2,
        PH_OP_ADR_D = 4'd3
    } phase_e;

    typedef struct packed {
        logic            start;
        logic            hold;
        logic [3:0]      phase;
        logic [OP_W-1:0] opcode;
    } ctrl_t;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [ADR_W-1:0] addr;
        logic [DAT_W-1:0] data;
        logic             held;
        logic             cs_n;
        logic             capture;
    } eng_t;

    typedef struct packed {
        logic               sclk;
        logic [FRAME_W-1:0] tx;
        logic [DAT_W-1:0]   rx;
        logic [CNT_W-1:0]   left;
    } shift_t;

endpackage

// File: rtl/spi_fce_clkgen.sv
module spi_fce_clkgen #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    generate
        if (HALF <= 1) begin : g_every_cycle
            assign tick = run;
        end else begin : g_counter
            localparam int CW = $clog2(HALF);
            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                tick  = run && (cnt_q == CW'(HALF - 1));
                cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end
        end
    endgenerate
endmodule

// File: rtl/spi_fce_shifter.sv
module spi_fce_shifter
    import spi_fce_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_word,
    input  logic [CNT_W-1:0]   load_bits,
    input  logic               tick,
    input  logic               miso,
    output logic               sclk,
    output logic               mosi,
    output logic               active,
    output logic               done,
    output logic [DAT_W-1:0]   rx_byte
);
    shift_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d.sclk = 1'b0;
            sh_d.tx   = load_word;
            sh_d.rx   = '0;
            sh_d.left = load_bits;
        end else if (tick && sh_q.left != '0) begin
            if (!sh_q.sclk) begin
                // rising edge: sample incoming bit
                sh_d.sclk = 1'b1;
                sh_d.rx   = {sh_q.rx[DAT_W-2:0], miso};
            end else begin
                // falling edge: present next outgoing bit
                sh_d.sclk = 1'b0;
                sh_d.tx   = {sh_q.tx[FRAME_W-2:0], 1'b0};
                sh_d.left = sh_q.left - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sclk    = sh_q.sclk;
    assign mosi    = sh_q.tx[FRAME_W-1];
    assign active  = (sh_q.left != '0);
    assign done    = tick && sh_q.sclk && (sh_q.left == CNT_W'(1));
    assign rx_byte = sh_q.rx;
endmodule

// File: rtl/spi_flash_cmd_engine.sv
module spi_flash_cmd_engine
    import spi_fce_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int CLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int HALF = (CLK_DIV < 2) ? 1 : CLK_DIV / 2;

    eng_t st_d, st_q;

    logic               tick, active, done, load;
    logic [FRAME_W-1:0] load_word;
    logic [CNT_W-1:0]   load_bits;
    logic [DAT_W-1:0]   rx_byte;
    logic               hit_ctrl, hit_addr, hit_data;
    logic [3:0]         new_phase;

    assign hit_ctrl  = (32'(reg_addr) == OFF_CTRL);
    assign hit_addr  = (32'(reg_addr) == OFF_ADDR);
    assign hit_data  = (32'(reg_addr) == OFF_DATA);
    assign new_phase = reg_wdata[11:8];

    always_comb begin
        st_d      = st_q;
        load      = 1'b0;
        load_word = '0;
        load_bits = '0;
        if (st_q.ctrl.start) begin
            if (done) begin
                st_d.ctrl.start = 1'b0;
                st_d.held       = st_q.ctrl.hold;
                st_d.cs_n       = !st_q.ctrl.hold;
                if (st_q.capture) st_d.data = rx_byte;
            end
        end else if (reg_wen) begin
            if (hit_addr) st_d.addr = reg_wdata[ADR_W-1:0];
            if (hit_data) st_d.data = reg_wdata[DAT_W-1:0];
            if (hit_ctrl) begin
                if (reg_wdata == '0) begin
                    st_d.ctrl = '0;
                    st_d.held = 1'b0;
                    st_d.cs_n = 1'b1;
                end else begin
                    st_d.ctrl.start  = reg_wdata[31];
                    st_d.ctrl.hold   = reg_wdata[12];
                    st_d.ctrl.phase  = new_phase;
                    st_d.ctrl.opcode = reg_wdata[OP_W-1:0];
                    if (reg_wdata[31]) begin
                        load      = 1'b1;
                        st_d.cs_n = 1'b0;
                        if (st_q.held) begin
                            load_word    = {st_q.data, {(OP_W + ADR_W){1'b0}}};
                            load_bits    = CNT_W'(DAT_W);
                            st_d.capture = 1'b1;
                        end else begin
                            unique case (new_phase)
                                PH_OP_DAT: begin
                                    load_word    = {reg_wdata[OP_W-1:0], st_q.data, {ADR_W{1'b0}}};
                                    load_bits    = CNT_W'(OP_W + DAT_W);
                                    st_d.capture = 1'b1;
                                end
                                PH_OP_ADR: begin
                                    load_word    = {reg_wdata[OP_W-1:0], st_q.addr, {DAT_W{1'b0}}};
                                    load_bits    = CNT_W'(OP_W + ADR_W);
                                    st_d.capture = 1'b0;
                                end
                                PH_OP_ADR_D: begin
                                    load_word    = {reg_wdata[OP_W-1:0], st_q.addr, st_q.data};
                                    load_bits    = CNT_W'(FRAME_W);
                                    st_d.capture = 1'b1;
                                end
                                default: begin
                                    load_word    = {reg_wdata[OP_W-1:0], {(ADR_W + DAT_W){1'b0}}};
                                    load_bits    = CNT_W'(OP_W);
                                    st_d.capture = 1'b0;
                                end
                            endcase
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cs_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (hit_ctrl)
            reg_rdata = {st_q.ctrl.start, 18'b0, st_q.ctrl.hold, st_q.ctrl.phase, st_q.ctrl.opcode};
        else if (hit_addr)
            reg_rdata = {{(32 - ADR_W){1'b0}}, st_q.addr};
        else if (hit_data)
            reg_rdata = {{(32 - DAT_W){1'b0}}, st_q.data};
    end

    spi_fce_clkgen #(.HALF(HALF)) i_clkgen (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (active),
        .tick (tick)
    );

    spi_fce_shifter i_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_word(load_word),
        .load_bits(load_bits),
        .tick     (tick),
        .miso     (spi_miso),
        .sclk     (spi_sclk),
        .mosi     (spi_mosi),
        .active   (active),
        .done     (done),
        .rx_byte  (rx_byte)
    );

    assign spi_cs_n = st_q.cs_n;
endmodule

// File: rtl/spi_fce_checker.sv
module spi_fce_checker
    import spi_fce_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wen,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              spi_cs_n,
    input logic              spi_sclk,
    input logic              spi_mosi,
    input logic              busy,
    input logic              held,
    input logic [ADR_W-1:0]  addr_reg
);
    logic ctrl_sel, addr_sel;
    assign ctrl_sel = reg_wen && (32'(reg_addr) == OFF_CTRL);
    assign addr_sel = reg_wen && (32'(reg_addr) == OFF_ADDR);

    // R5
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // R5
    mosi_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    // R3
    launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_sel && !busy && reg_wdata[31]) |=> (busy && !spi_cs_n));

    // R8
    release_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_sel && !busy && reg_wdata == 32'd0) |=> (spi_cs_n && !held));

    // R9
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_sel && busy) |=> $stable(addr_reg));

    // R7
    held_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> !spi_cs_n);
endmodule

bind spi_flash_cmd_engine spi_fce_checker #(.ADDR_W(ADDR_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wen  (reg_wen),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .spi_cs_n (spi_cs_n),
    .spi_sclk (spi_sclk),
    .spi_mosi (spi_mosi),
    .busy     (st_q.ctrl.start),
    .held     (st_q.held),
    .addr_reg (st_q.addr)
);

// File: tb/test_spi_flash_cmd_engine.sv
`timescale 1ns/1ps
module test_spi_flash_cmd_engine;
    localparam int CLK_DIV = 4;
    localparam int ADDR_W  = 8;
    localparam logic [7:0] A_CTRL = 8'h40;
    localparam logic [7:0] A_ADDR = 8'h44;
    localparam logic [7:0] A_DATA = 8'h48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_sclk, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    int mon_total = 0;
    int base = 0;
    int per_err = 0;
    int mode_err = 0;
    int cs_err = 0;
    logic [63:0] mon_bits = '0;
    logic [63:0] miso_pat = '0;
    realtime last_rise = 0.0;

    always #2.5 clk = ~clk;

    spi_flash_cmd_engine #(.ADDR_W(ADDR_W), .CLK_DIV(CLK_DIV)) i_spi_flash_cmd_engine (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // flash pin model
    always @(posedge spi_sclk) begin
        if (spi_cs_n) cs_err++;
        if (mon_total != base && ($realtime - last_rise) != CLK_DIV * 5.0) per_err++;
        last_rise = $realtime;
        mon_bits  = {mon_bits[62:0], spi_mosi};
        mon_total++;
    end
    always @(negedge spi_sclk)
        if (mon_total - base < 64) spi_miso = miso_pat[63 - (mon_total - base)];
    always @(spi_mosi)
        if (spi_sclk === 1'b1) mode_err++;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic start_cmd(input logic [31:0] word);
        base = mon_total;
        spi_miso = miso_pat[63];
        bus_write(A_CTRL, word);
    endtask

    task automatic wait_cmd(input int exp_n, input logic [63:0] exp_tx, input string req);
        logic [31:0] r;
        int polls;
        logic [63:0] mask;
        polls = 0;
        bus_read(A_CTRL, r);
        check(r[31] == 1'b1, "R3 busy reads set while running", 64'(r[31]), 64'd1);
        while (r[31] && polls < 5000) begin
            bus_read(A_CTRL, r);
            polls++;
        end
        check(r[31] == 1'b0, "R3 busy clears at completion", 64'(r[31]), 64'd0);
        check(mon_total - base == exp_n, "R4 clock count", 64'(mon_total - base), 64'(exp_n));
        mask = (64'd1 << exp_n) - 64'd1;
        check((mon_bits & mask) == exp_tx, req, mon_bits & mask, exp_tx);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            $display("FAIL R3 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int          code, n;
        logic [7:0]  op, dv, cap;
        logic [23:0] ad;
        logic [63:0] exp_tx;

        repeat (4) @(negedge clk);
        check(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R1 pins in reset", {spi_cs_n, spi_sclk}, 64'h2);
        rst_n = 1'b1;
        bus_read(A_CTRL, r); check(r == 0, "R1 control after reset", r, 0);
        bus_read(A_ADDR, r); check(r == 0, "R1 address after reset", r, 0);
        bus_read(A_DATA, r); check(r == 0, "R1 data after reset", r, 0);
        check(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R1 pins after reset", {spi_cs_n, spi_sclk}, 64'h2);

        // R2 field widths
        bus_write(A_ADDR, 32'hFFFF_FFFF);
        bus_read(A_ADDR, r); check(r == 32'h00FF_FFFF, "R2 address width", r, 32'h00FF_FFFF);
        bus_write(A_DATA, 32'hFFFF_FFFF);
        bus_read(A_DATA, r); check(r == 32'h0000_00FF, "R2 data width", r, 32'hFF);
        bus_read(8'h4C, r); check(r == 0, "R2 unmapped offset", r, 0);

        // R10 store-only control write
        base = mon_total;
        bus_write(A_CTRL, 32'h7FFF_E203);
        repeat (40) @(negedge clk);
        check(mon_total == base, "R10 no clocks without start", 64'(mon_total - base), 0);
        check(spi_cs_n == 1'b1, "R10 select unchanged", spi_cs_n, 1);
        bus_read(A_CTRL, r); check(r == 32'h0000_0203, "R2 R10 control fields stored", r, 32'h203);

        // R4 R6 sweep over every phase code
        for (int i = 0; i < 32; i++) begin
            code = i % 16;
            op = 8'h03 + 8'(i * 37);
            ad = 24'h5A0000 ^ 24'(i * 66051);
            dv = 8'hC3 ^ 8'(i * 11);
            miso_pat = 64'h0F1E_2D3C_4B5A_6978 ^ {8{8'(i * 29)}};
            bus_write(A_ADDR, {8'hEE, ad});
            bus_write(A_DATA, {24'hFFFFFF, dv});
            bus_read(A_ADDR, r); check(r == {8'h00, ad}, "R2 address readback", r, {8'h00, ad});
            case (code)
                1:       begin n = 16; exp_tx = 64'({op, dv}); end
                2:       begin n = 32; exp_tx = 64'({op, ad}); end
                3:       begin n = 40; exp_tx = 64'({op, ad, dv}); end
                default: begin n = 8;  exp_tx = 64'(op); end
            endcase
            start_cmd({1'b1, 19'b0, 4'(code), op});
            wait_cmd(n, exp_tx, "R4 R5 frame bits MSB first");
            cap = miso_pat[71 - n -: 8];
            bus_read(A_DATA, r);
            if (code == 1 || code == 3)
                check(r == {24'b0, cap}, "R6 captured byte", r, {24'b0, cap});
            else
                check(r == {24'b0, dv}, "R6 data kept without data phase", r, {24'b0, dv});
            bus_read(A_CTRL, r);
            check(r == {20'b0, 4'(code), op}, "R3 fields kept after completion", r, {20'b0, 4'(code), op});
            check(spi_cs_n == 1'b1, "R3 select released", spi_cs_n, 1);
        end

        // R7 held page program chain
        miso_pat = 64'h8C4A_2F91_D37E_05B6;
        bus_write(A_ADDR, 32'h00AB_CDEF);
        bus_write(A_DATA, 32'h0000_00A5);
        start_cmd(32'h8000_1302);
        wait_cmd(40, 64'h02_ABCDEF_A5, "R7 first held command full frame");
        check(spi_cs_n == 1'b0, "R7 select held", spi_cs_n, 0);
        bus_read(A_CTRL, r); check(r == 32'h0000_1302, "R2 hold bit readback", r, 32'h1302);
        bus_write(A_DATA, 32'h0000_003C);
        start_cmd(32'h8000_1302);
        wait_cmd(8, 64'h3C, "R7 follow-on sends data only");
        check(spi_cs_n == 1'b0, "R7 select still held", spi_cs_n, 0);
        bus_write(A_DATA, 32'h0000_005A);
        start_cmd(32'h8000_0077);
        wait_cmd(8, 64'h5A, "R7 last byte data only");
        check(spi_cs_n == 1'b1, "R7 select released by hold clear", spi_cs_n, 1);
        bus_read(A_DATA, r); check(r == {24'b0, miso_pat[63:56]}, "R6 R7 held byte captured", r, miso_pat[63:56]);

        // R8 release by writing zero
        start_cmd(32'h8000_1005);
        wait_cmd(8, 64'h05, "R7 opcode with hold");
        check(spi_cs_n == 1'b0, "R7 select held before release", spi_cs_n, 0);
        bus_write(A_CTRL, 32'h0);
        check(spi_cs_n == 1'b1, "R8 zero write releases select", spi_cs_n, 1);
        bus_read(A_CTRL, r); check(r == 0, "R8 control cleared", r, 0);
        bus_write(A_DATA, 32'h0000_0011);
        start_cmd(32'h8000_0105);
        wait_cmd(16, 64'h0511, "R8 full frame after release");

        // R9 writes during a running command
        bus_write(A_ADDR, 32'h0011_1111);
        bus_write(A_DATA, 32'h0000_0022);
        start_cmd(32'h8000_0302);
        bus_write(A_ADDR, 32'h0099_9999);
        bus_write(A_DATA, 32'h0000_0077);
        bus_write(A_CTRL, 32'h0);
        check(spi_cs_n == 1'b0, "R9 zero write ignored while busy", spi_cs_n, 0);
        wait_cmd(40, 64'h02_111111_22, "R9 frame unaffected by writes");
        bus_read(A_ADDR, r); check(r == 32'h0011_1111, "R9 address write ignored", r, 32'h111111);
        bus_read(A_CTRL, r); check(r == 32'h0000_0302, "R9 control write ignored", r, 32'h302);
        bus_read(A_DATA, r); check(r == {24'b0, miso_pat[31:24]}, "R9 data write ignored", r, miso_pat[31:24]);

        check(per_err == 0, "R5 rising edge spacing", per_err, 0);
        check(mode_err == 0, "R5 mosi changed while sclk high", mode_err, 0);
        check(cs_err == 0, "R5 clock edge with select high", cs_err, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule